// File: doc/BRIEF.md
# Next-PC Resolver for Jumps and Branches

This block decides where a small core fetches next. Each cycle it receives the opcode of the instruction at the current program counter, the counter itself, two 16-bit register operands and the instruction's immediate field. It then registers the resolved next counter together with a flag that tells fetch whether the flow was redirected. Four opcodes redirect flow. The absolute jump takes its target from the immediate. The indirect jump takes its target from the first register operand. Two conditional branches compare the register operands for equality or for inequality, and when the condition holds they add the immediate, read as a signed offset, to the current counter. Every other opcode falls through to the next instruction. Instructions are two 16-bit words long, so the fall-through step is 2 in word addresses.

Internally the result is held as an outcome state plus a target register. The outcome states are IDLE (entered on reset, no target yet), SEQ (fall-through), ABS (absolute jump), IND (register-indirect jump) and REL (taken relative branch). From any state the next clock edge moves to the state chosen for the incoming opcode. JMP goes to ABS and JMPR goes to IND. BEQ goes to REL if the operands match and to SEQ if they do not, and BNE is the reverse. Any other opcode goes to SEQ. Only reset returns the block to IDLE. The taken flag is asserted in ABS, IND and REL.

Top module: `npc_resolve`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, the next-PC output is 0 and the taken flag is 0.
- R2: Opcode 6'h10 (absolute jump) makes the next-PC output equal to the low 16 bits of the 21-bit immediate one clock edge later, with the taken flag at 1. The upper immediate bits are dropped.
- R3: Opcode 6'h11 (indirect jump) makes the next-PC output equal to the first register operand one edge later, with the taken flag at 1.
- R4: Opcode 6'h12 (branch if equal) with equal operands gives current PC plus the immediate, read as a 21-bit two's-complement offset, modulo 2^16, with the flag at 1. With unequal operands it gives current PC plus 2 with the flag at 0.
- R5: Opcode 6'h13 (branch if not equal) with unequal operands gives current PC plus the signed offset, modulo 2^16, with the flag at 1. With equal operands it gives current PC plus 2 with the flag at 0.
- R6: Any other opcode gives current PC plus 2 with the flag at 0. The register operands and the immediate have no effect on the result.
- R7: All targets wrap modulo 2^16. A fall-through from 16'hFFFE gives 16'h0000, and a negative offset below address 0 wraps to the top of the address space.
- R8: A taken branch whose target equals the fall-through address (offset +2) still reports the taken flag as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Opcode of the current instruction |
| pc_i | input | 16 | Current program counter (word address) |
| ra_i | input | 16 | First register operand |
| rb_i | input | 16 | Second register operand |
| imm_i | input | 21 | Immediate field (absolute address or signed offset) |
| npc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered redirect flag |

## Verification
In a single cycle the equality test can make a branch fall through while the adder produces the sequential address, and a taken relative target can produce that same address. The two outcomes are then told apart only by the taken flag. The bench provokes this with directed branches whose offset is +2, in both the taken and the untaken direction. It also biases random operands so that they are often equal. Each registered result is judged by comparing both npc_o and taken_o against a bench model that resolves the opcode from the requirements.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Control-flow opcode encodings
    localparam logic [5:0] OPC_JMP  = 6'h10;
    localparam logic [5:0] OPC_JMPR = 6'h11;
    localparam logic [5:0] OPC_BEQ  = 6'h12;
    localparam logic [5:0] OPC_BNE  = 6'h13;

    // Resolution outcome held in the state register
    typedef enum logic [2:0] {
        RES_IDLE = 3'd0,
        RES_SEQ  = 3'd1,
        RES_ABS  = 3'd2,
        RES_IND  = 3'd3,
        RES_REL  = 3'd4
    } res_e;

endpackage

// File: rtl/npc_cmp.sv
// Chunked equality comparator for the branch condition.
module npc_cmp #(
    parameter int W     = 16,
    parameter int CHUNK = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    localparam int NCH = (W + CHUNK - 1) / CHUNK;
    localparam int PW  = NCH * CHUNK;

    logic [PW-1:0]  a_pad;
    logic [PW-1:0]  b_pad;
    logic [NCH-1:0] chunk_eq;

    assign a_pad = PW'(a_i);
    assign b_pad = PW'(b_i);

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        assign chunk_eq[g] = (a_pad[g*CHUNK +: CHUNK] == b_pad[g*CHUNK +: CHUNK]);
    end

    assign eq_o = &chunk_eq;

endmodule

// File: rtl/npc_decode.sv
// Maps opcode and comparison result to the next outcome state.
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic       eq_i,
    output res_e       sel_o
);
    always_comb begin
        unique case (op_i)
            OPC_JMP:  sel_o = RES_ABS;
            OPC_JMPR: sel_o = RES_IND;
            OPC_BEQ:  sel_o = eq_i ? RES_REL : RES_SEQ;
            OPC_BNE:  sel_o = eq_i ? RES_SEQ : RES_REL;
            default:  sel_o = RES_SEQ;
        endcase
    end

    // A decoded outcome is never the reset-only state
    always_comb begin
        AST_DECODE_NOT_IDLE: assert (sel_o != RES_IDLE); // R6
    end

endmodule

// File: rtl/npc_addr.sv
// Candidate target generation: sequential, absolute and PC-relative.
module npc_addr #(
    parameter int PC_W  = 16,
    parameter int IMM_W = 21,
    parameter int STEP  = 2
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  abs_o,
    output logic [PC_W-1:0]  rel_o
);
    localparam int EXT_W = (PC_W > IMM_W) ? PC_W : IMM_W;

    logic signed [EXT_W-1:0] off_ext;

    assign off_ext = EXT_W'(signed'(imm_i));
    assign seq_o   = pc_i + PC_W'(STEP);
    assign abs_o   = PC_W'(imm_i);
    assign rel_o   = pc_i + off_ext[PC_W-1:0];

endmodule

// File: rtl/npc_resolve.sv
// Next-PC resolution: registered outcome state and target.
module npc_resolve
    import npc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 21,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       op_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  ra_i,
    input  logic [PC_W-1:0]  rb_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [PC_W-1:0]  npc_o,
    output logic             taken_o
);
    logic            eq;
    res_e            sel;
    res_e            state_q;
    logic [PC_W-1:0] seq_t, abs_t, rel_t;
    logic [PC_W-1:0] tgt_d, tgt_q;

    npc_cmp #(.W(PC_W), .CHUNK(4)) u_cmp (
        .a_i  (ra_i),
        .b_i  (rb_i),
        .eq_o (eq)
    );

    npc_decode u_dec (
        .op_i  (op_i),
        .eq_i  (eq),
        .sel_o (sel)
    );

    npc_addr #(.PC_W(PC_W), .IMM_W(IMM_W), .STEP(STEP)) u_addr (
        .pc_i  (pc_i),
        .imm_i (imm_i),
        .seq_o (seq_t),
        .abs_o (abs_t),
        .rel_o (rel_t)
    );

    // Target selection for the chosen outcome
    always_comb begin
        unique case (sel)
            RES_ABS: tgt_d = abs_t;
            RES_IND: tgt_d = ra_i;
            RES_REL: tgt_d = rel_t;
            default: tgt_d = seq_t;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= sel;
            tgt_q   <= tgt_d;
        end
    end

    // Outputs
    always_comb begin
        npc_o = tgt_q;
        unique case (state_q)
            RES_ABS, RES_IND, RES_REL: taken_o = 1'b1;
            default:                   taken_o = 1'b0;
        endcase
    end

    // Assertions
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (npc_o == '0 && !taken_o); // R1
        end
    end

    AST_JMP_ABS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_JMP) |=> (taken_o && npc_o == PC_W'($past(imm_i)))); // R2

    AST_JMPR_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_JMPR) |=> (taken_o && npc_o == $past(ra_i))); // R3

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_BEQ && ra_i != rb_i) |=>
            (!taken_o && npc_o == $past(pc_i) + PC_W'(STEP))); // R4

    AST_BNE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OPC_BNE && ra_i == rb_i) |=>
            (!taken_o && npc_o == $past(pc_i) + PC_W'(STEP))); // R5

    AST_OTHER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OPC_JMP && op_i != OPC_JMPR && op_i != OPC_BEQ && op_i != OPC_BNE) |=>
            (!taken_o && npc_o == $past(pc_i) + PC_W'(STEP))); // R6

    AST_NO_IDLE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q != RES_IDLE)); // R8

endmodule

// File: tb/npc_resolve_test.sv
module npc_resolve_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_i = '0;
    logic [15:0] pc_i = '0, ra_i = '0, rb_i = '0;
    logic [20:0] imm_i = '0;
    logic [15:0] npc_o;
    logic        taken_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    npc_resolve uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .pc_i(pc_i),
        .ra_i(ra_i), .rb_i(rb_i), .imm_i(imm_i),
        .npc_o(npc_o), .taken_o(taken_o)
    );

    function automatic logic [15:0] seq_of(input logic [15:0] pc);
        int v = int'(pc) + 2;
        return 16'(v % 65536);
    endfunction

    function automatic logic [15:0] rel_of(input logic [15:0] pc, input logic [20:0] imm);
        int off = imm[20] ? int'(imm) - (1 << 21) : int'(imm);
        int v   = int'(pc) + off;
        v = ((v % 65536) + 65536) % 65536;
        return 16'(v);
    endfunction

    function automatic logic [16:0] model(input logic [5:0] op, input logic [15:0] pc,
                                          input logic [15:0] a, input logic [15:0] b,
                                          input logic [20:0] imm);
        if (op == 6'h10) return {1'b1, imm[15:0]};
        if (op == 6'h11) return {1'b1, a};
        if (op == 6'h12) return (a == b) ? {1'b1, rel_of(pc, imm)} : {1'b0, seq_of(pc)};
        if (op == 6'h13) return (a != b) ? {1'b1, rel_of(pc, imm)} : {1'b0, seq_of(pc)};
        return {1'b0, seq_of(pc)};
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'h10:   return "R2";
            6'h11:   return "R3";
            6'h12:   return "R4";
            6'h13:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] exp);
        checks++;
        if ({taken_o, npc_o} !== exp) begin
            fails++;
            $display("FAIL %s: got taken=%0b npc=%h, expected taken=%0b npc=%h",
                     req, taken_o, npc_o, exp[16], exp[15:0]);
        end
    endtask

    // Drive on the falling edge, sample just after the next rising edge
    task automatic step(input string req, input logic [5:0] op, input logic [15:0] pc,
                        input logic [15:0] a, input logic [15:0] b, input logic [20:0] imm);
        @(negedge clk);
        op_i = op; pc_i = pc; ra_i = a; rb_i = b; imm_i = imm;
        @(posedge clk);
        #1;
        check(req, model(op, pc, a, b, imm));
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        op_i = 6'h12; ra_i = 16'h5; rb_i = 16'h5; imm_i = 21'h1234; pc_i = 16'h100;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 17'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 after release", 17'h0);

        // Directed cases
        step("R2 high imm bits dropped", 6'h10, 16'h0040, 16'h1, 16'h2, 21'h1F_ABCD);
        step("R3 indirect",              6'h11, 16'h0040, 16'hBEEF, 16'h0, 21'h0);
        step("R4 equal negative offset", 6'h12, 16'h0100, 16'h7, 16'h7, 21'h1F_FFF0);
        step("R4 unequal falls through", 6'h12, 16'h0100, 16'h7, 16'h8, 21'h0_0020);
        step("R5 unequal taken",         6'h13, 16'h0200, 16'h1, 16'h8000, 21'h0_0010);
        step("R5 equal falls through",   6'h13, 16'h0200, 16'hFFFF, 16'hFFFF, 21'h0_0010);
        step("R6 neighbour opcode 14",   6'h14, 16'h0300, 16'hAAAA, 16'hAAAA, 21'h1F_FFFF);
        step("R6 neighbour opcode 0F",   6'h0F, 16'h0300, 16'h1234, 16'h4321, 21'h0_5555);
        step("R7 fall-through wrap",     6'h00, 16'hFFFE, 16'h0, 16'h0, 21'h0);
        step("R7 relative wrap below 0", 6'h12, 16'h0004, 16'h3, 16'h3, 21'h1F_FFF8);
        step("R7 relative wrap above",   6'h13, 16'hFFF0, 16'h3, 16'h4, 21'h0_0020);
        step("R8 taken offset +2 BEQ",   6'h12, 16'h0500, 16'h9, 16'h9, 21'h0_0002);
        step("R8 taken offset +2 BNE",   6'h13, 16'h0500, 16'h9, 16'hA, 21'h0_0002);
        step("R8 untaken offset +2 BEQ", 6'h12, 16'h0500, 16'h9, 16'hA, 21'h0_0002);

        // Constrained random
        for (int i = 0; i < 500; i++) begin
            logic [5:0]  op;
            logic [15:0] a, b;
            int sel = $urandom_range(0, 9);
            op = (sel < 8) ? 6'(6'h10 + (sel % 4)) : 6'($urandom_range(0, 63));
            a  = 16'($urandom);
            b  = ($urandom_range(0, 1) == 1) ? a : 16'($urandom);
            step(req_of(op), op, 16'($urandom), a, b, 21'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule